// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a 32-bit SDRAM array from power-up to a usable state and then keeps it refreshed. It does not drive the memory pins. It issues command requests (precharge-all, auto-refresh, mode register set, dummy read and dummy write) over a valid/ready command stream to a downstream memory controller. Each request carries an operation code and an address. The mode value is placed on the address field shifted to suit a 32-bit-wide port.

After a power-up wait the sequencer runs this order: a precharge-all and a first mode set, then two bursts of four auto-refreshes, then a second mode set with no precharge before it. A quiet gap separates each command group. The periodic refresh timer starts with the second mode set. Ten dummy read/write pairs follow before the block raises its done flag. From then on it only forwards refresh requests.

The refresh rate halves while the small-memory input is high. The column-mode input is passed through a register to the address-multiplexing select.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and for at least PWRUP_CYCLES clock cycles after reset is released, cmd_valid_o and init_done_o are low.
- R2: The first two accepted commands are a precharge-all (op 1, address 0) and then a mode set (op 3).
- R3: The next INIT_GROUPS (2) groups of BURST (4) commands are auto-refreshes (op 2, address 0). That is 8 refreshes in total.
- R4: A second mode set (op 3) follows the refresh groups, with no precharge-all between them.
- R5: Every mode set carries the address MODE_VALUE shifted left by 2. With the default 0x22 that is 0x88.
- R6: Command groups are separated by at least GAP_CYCLES cycles with cmd_valid_o low. The groups are {precharge, mode set}, each refresh burst, and the second mode set. Consecutive acceptances across a group boundary are therefore at least GAP_CYCLES+1 cycles apart.
- R7: The periodic timer starts only once the second mode set is issued. Before that exactly 8 refreshes are issued. After it, BURST refreshes are queued every PRESCALE*PERIOD cycles.
- R8: While small_mem_i is high, the refresh interval doubles to 2*PRESCALE*PERIOD cycles.
- R9: After the second mode set, DUMMIES (10) pairs are issued as a dummy read (op 4) followed by a dummy write (op 5). Pair i uses address 4*i.
- R10: init_done_o rises in the cycle after the last dummy write is accepted and then stays high.
- R11: Periodic refreshes take priority over dummy accesses. A refresh that falls due while the stream is stalled is queued (up to QUEUE_GROUPS*BURST) rather than dropped.
- R12: Once cmd_valid_o is high, it stays high with cmd_op_o and cmd_addr_o unchanged until cmd_ready_i accepts the command.
- R13: mux_9col_o equals col_9_i delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| small_mem_i | input | 1 | Memory is 32 MB or less; halves the refresh rate |
| col_9_i | input | 1 | 1 selects 9-column address multiplexing, 0 selects 8 |
| cmd_valid_o | output | 1 | Command request valid |
| cmd_ready_i | input | 1 | Downstream controller accepts the command |
| cmd_op_o | output | 3 | Operation: 1 precharge-all, 2 refresh, 3 mode set, 4 dummy read, 5 dummy write |
| cmd_addr_o | output | ADDR_W | Command address (byte address) |
| mux_9col_o | output | 1 | Registered column-mode select |
| init_done_o | output | 1 | Initialization complete |

## Verification
The assertions assume that the downstream controller may drop cmd_ready_i at any time. They also assume that small_mem_i changes only between refresh groups, and that the controller never sees the stream outside reset before the clock runs. The stimulus stalls the stream in a repeating pattern during initialization and holds it off for several refresh intervals afterwards. It changes small_mem_i only while the stream flows. Interval measurements are taken only after two undisturbed groups have passed.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PRECHARGE = 3'd1,
    OP_REFRESH   = 3'd2,
    OP_MODE      = 3'd3,
    OP_DRD       = 3'd4,
    OP_DWR       = 3'd5
  } sdi_op_e;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_PRE,
    ST_MRS1,
    ST_GAP,
    ST_REF,
    ST_MRS2,
    ST_DUMMY,
    ST_FLUSH,
    ST_READY
  } sdi_state_e;

endpackage

// File: rtl/sdi_refresh_timer.sv
module sdi_refresh_timer #(
  parameter int PRESCALE = 8,
  parameter int PERIOD   = 195
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic slow_i,
  output logic expire_o
);
  localparam int DIV_SLOW = 2 * PRESCALE;
  localparam int PW = $clog2(DIV_SLOW + 1);
  localparam int TW = $clog2(PERIOD + 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] per_q;
  logic [PW-1:0] div_now;
  logic          tick;

  assign div_now  = slow_i ? PW'(DIV_SLOW) : PW'(PRESCALE);
  assign tick     = enable_i && (pre_q >= div_now - PW'(1));
  assign expire_o = tick && (per_q == TW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable_i) begin
      pre_q <= '0;
      per_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      per_q <= (per_q == TW'(PERIOD - 1)) ? '0 : per_q + TW'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

endmodule

// File: rtl/sdi_refresh_queue.sv
module sdi_refresh_queue #(
  parameter int BURST        = 4,
  parameter int QUEUE_GROUPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic add_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int MAXC = BURST * QUEUE_GROUPS;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  int            sum;

  always_comb begin
    sum = int'(cnt_q) + (add_i ? BURST : 0) - (take_i ? 1 : 0);
    if (sum > MAXC) sum = MAXC;
    if (sum < 0)    sum = 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable_i) cnt_q <= '0;
    else                     cnt_q <= CW'(sum);
  end

  assign pend_o = (cnt_q != '0);

  AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> cnt_q != '0); // R11

endmodule

// File: rtl/sdi_seq_fsm.sv
module sdi_seq_fsm
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PWRUP_CYCLES = 10000,
  parameter int GAP_CYCLES  = 100,
  parameter int BURST       = 4,
  parameter int INIT_GROUPS = 2,
  parameter int DUMMIES     = 10,
  parameter int MODE_VALUE  = 'h22,
  parameter int MODE_SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_free_i,
  input  logic              out_idle_i,
  input  logic              out_accept_i,
  input  logic              pend_i,
  output logic              nxt_valid_o,
  output sdi_op_e           nxt_op_o,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic              take_o,
  output logic              ref_en_o,
  output logic              done_o
);
  localparam int WMAX = (PWRUP_CYCLES > GAP_CYCLES) ? PWRUP_CYCLES : GAP_CYCLES;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int BW   = $clog2(BURST + 1);
  localparam int GW   = $clog2(INIT_GROUPS + 1);
  localparam int DW   = $clog2(DUMMIES + 1);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_VALUE) << MODE_SHIFT;

  sdi_state_e    state_q, tgt_q;
  logic [WW-1:0] wait_q;
  logic [BW-1:0] burst_q;
  logic [GW-1:0] group_q;
  logic [DW-1:0] word_q;
  logic          wr_q;
  logic          from_q, load, own;

  always_comb begin
    nxt_valid_o = 1'b0;
    nxt_op_o    = OP_NONE;
    nxt_addr_o  = '0;
    from_q      = 1'b0;
    unique case (state_q)
      ST_PRE: begin
        nxt_valid_o = 1'b1;
        nxt_op_o    = OP_PRECHARGE;
      end
      ST_MRS1, ST_MRS2: begin
        nxt_valid_o = 1'b1;
        nxt_op_o    = OP_MODE;
        nxt_addr_o  = MODE_ADDR;
      end
      ST_REF: begin
        nxt_valid_o = 1'b1;
        nxt_op_o    = OP_REFRESH;
      end
      ST_DUMMY: begin
        nxt_valid_o = 1'b1;
        if (pend_i) begin
          nxt_op_o = OP_REFRESH;
          from_q   = 1'b1;
        end else begin
          nxt_op_o   = wr_q ? OP_DWR : OP_DRD;
          nxt_addr_o = ADDR_W'(word_q) << 2;
        end
      end
      ST_READY: begin
        if (pend_i) begin
          nxt_valid_o = 1'b1;
          nxt_op_o    = OP_REFRESH;
          from_q      = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign load   = slot_free_i && nxt_valid_o;
  assign take_o = load && from_q;
  assign own    = load && !from_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_PWR;
      tgt_q    <= ST_REF;
      wait_q   <= WW'(PWRUP_CYCLES - 1);
      burst_q  <= '0;
      group_q  <= '0;
      word_q   <= '0;
      wr_q     <= 1'b0;
      ref_en_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PWR: begin
          if (wait_q == '0) state_q <= ST_PRE;
          else              wait_q  <= wait_q - WW'(1);
        end
        ST_PRE: if (own) state_q <= ST_MRS1;
        ST_MRS1: if (own) begin
          state_q <= ST_GAP;
          tgt_q   <= ST_REF;
          wait_q  <= WW'(GAP_CYCLES - 1);
        end
        ST_GAP: if (out_idle_i) begin
          if (wait_q == '0) state_q <= tgt_q;
          else              wait_q  <= wait_q - WW'(1);
        end
        ST_REF: if (own) begin
          if (burst_q == BW'(BURST - 1)) begin
            burst_q <= '0;
            state_q <= ST_GAP;
            wait_q  <= WW'(GAP_CYCLES - 1);
            if (group_q == GW'(INIT_GROUPS - 1)) begin
              group_q <= '0;
              tgt_q   <= ST_MRS2;
            end else begin
              group_q <= group_q + GW'(1);
              tgt_q   <= ST_REF;
            end
          end else begin
            burst_q <= burst_q + BW'(1);
          end
        end
        ST_MRS2: if (own) begin
          ref_en_o <= 1'b1;
          state_q  <= ST_GAP;
          tgt_q    <= ST_DUMMY;
          wait_q   <= WW'(GAP_CYCLES - 1);
        end
        ST_DUMMY: if (own) begin
          if (wr_q) begin
            wr_q <= 1'b0;
            if (word_q == DW'(DUMMIES - 1)) state_q <= ST_FLUSH;
            else                            word_q  <= word_q + DW'(1);
          end else begin
            wr_q <= 1'b1;
          end
        end
        ST_FLUSH: if (out_accept_i) begin
          state_q <= ST_READY;
          done_o  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PWRUP_CYCLES = 10000,
  parameter int GAP_CYCLES   = 100,
  parameter int PRESCALE     = 8,
  parameter int PERIOD       = 195,
  parameter int BURST        = 4,
  parameter int INIT_GROUPS  = 2,
  parameter int QUEUE_GROUPS = 4,
  parameter int DUMMIES      = 10,
  parameter int MODE_VALUE   = 'h22,
  parameter int MODE_SHIFT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              small_mem_i,
  input  logic              col_9_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              mux_9col_o,
  output logic              init_done_o
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_VALUE) << MODE_SHIFT;

  logic              slot_free, accept;
  logic              nxt_valid, take, ref_en, pend, expire;
  sdi_op_e           nxt_op;
  logic [ADDR_W-1:0] nxt_addr;

  assign slot_free = !cmd_valid_o || cmd_ready_i;
  assign accept    = cmd_valid_o && cmd_ready_i;

  sdi_seq_fsm #(
    .ADDR_W(ADDR_W), .PWRUP_CYCLES(PWRUP_CYCLES), .GAP_CYCLES(GAP_CYCLES),
    .BURST(BURST), .INIT_GROUPS(INIT_GROUPS), .DUMMIES(DUMMIES),
    .MODE_VALUE(MODE_VALUE), .MODE_SHIFT(MODE_SHIFT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .slot_free_i(slot_free), .out_idle_i(!cmd_valid_o),
    .out_accept_i(accept), .pend_i(pend), .nxt_valid_o(nxt_valid), .nxt_op_o(nxt_op),
    .nxt_addr_o(nxt_addr), .take_o(take), .ref_en_o(ref_en), .done_o(init_done_o)
  );

  sdi_refresh_timer #(.PRESCALE(PRESCALE), .PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable_i(ref_en), .slow_i(small_mem_i), .expire_o(expire)
  );

  sdi_refresh_queue #(.BURST(BURST), .QUEUE_GROUPS(QUEUE_GROUPS)) u_queue (
    .clk(clk), .rst_n(rst_n), .enable_i(ref_en), .add_i(expire), .take_i(take), .pend_o(pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= OP_NONE;
      cmd_addr_o  <= '0;
      mux_9col_o  <= 1'b0;
    end else begin
      mux_9col_o <= col_9_i;
      if (slot_free) begin
        cmd_valid_o <= nxt_valid;
        if (nxt_valid) begin
          cmd_op_o   <= nxt_op;
          cmd_addr_o <= nxt_addr;
        end
      end
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o)); // R12

  AST_MODE_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_op_o == OP_MODE |-> cmd_addr_o == MODE_ADDR); // R5

  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o); // R10

  AST_DONE_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> $past(accept && cmd_op_o == OP_DWR)); // R10

  AST_NO_REFRESH_BEFORE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ref_en); // R7

endmodule

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;
  import sdram_init_pkg::*;

  localparam int ADDR_W = 16;
  localparam int PWRUP  = 60;
  localparam int GAP    = 5;
  localparam int PRESC  = 2;
  localparam int PER    = 12;
  localparam int BURST  = 4;
  localparam int DUMS   = 10;
  localparam int INTV   = PRESC * PER;
  localparam int LAST_IDX = 11 + 2 * DUMS - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic small_mem = 1'b0;
  logic col9 = 1'b0;
  logic cmd_ready = 1'b1;
  logic cmd_valid, mux9, done;
  logic [2:0] cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .PWRUP_CYCLES(PWRUP), .GAP_CYCLES(GAP), .PRESCALE(PRESC),
    .PERIOD(PER), .BURST(BURST), .INIT_GROUPS(2), .QUEUE_GROUPS(4), .DUMMIES(DUMS),
    .MODE_VALUE('h22), .MODE_SHIFT(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .small_mem_i(small_mem), .col_9_i(col9),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_addr_o(cmd_addr), .mux_9col_o(mux9), .init_done_o(done)
  );

  typedef struct { int op; int addr; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rdy_mode = 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_exp(input int op, input int addr);
    exp_t e;
    e.op = op; e.addr = addr;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: cmd_ready = 1'b1;
        1: cmd_ready = (cyc % 3) != 0;
        default: cmd_ready = 1'b0;
      endcase
    end
  end

  // monitor state
  bit first_seen = 0, prev_stall = 0, gap_pending = 0, chk_done_next = 0;
  bit last_wr_seen = 0, early_done_flagged = 0, have_grp = 0;
  int prev_op = 0, prev_addr = 0, gap_from = 0, idx = 0, mrs_seen = 0;
  int pre_refs = 0, refs_in_dummy = 0, last_ref_cyc = -10, run = 0, max_run = 0;
  int last_grp = 0, last_intv = 0, grp_count = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid && !first_seen) begin
      first_seen = 1;
      chk(cyc >= PWRUP, "R1 first command cycle", cyc, PWRUP);
    end
    if (prev_stall)
      chk(cmd_valid && int'(cmd_op) == prev_op && int'(cmd_addr) == prev_addr,
          "R12 held command", int'(cmd_op), prev_op);
    if (chk_done_next) begin
      chk(done == 1'b1, "R10 done after last write", done, 1);
      chk_done_next = 0;
    end
    if (done && !last_wr_seen && !early_done_flagged) begin
      early_done_flagged = 1;
      chk(0, "R10 done too early", 1, 0);
    end
    if (cmd_valid && cmd_ready) begin
      if (gap_pending) begin
        chk(cyc - gap_from >= GAP + 1, "R6 group gap", cyc - gap_from, GAP + 1);
        gap_pending = 0;
      end
      if (int'(cmd_op) == int'(OP_REFRESH) && mrs_seen >= 2) begin
        if (!done) refs_in_dummy++;
        if (last_ref_cyc == cyc - 1) run++;
        else begin
          run = 1;
          if (have_grp) last_intv = cyc - last_grp;
          have_grp = 1;
          last_grp = cyc;
          grp_count++;
        end
        if (run > max_run) max_run = run;
        last_ref_cyc = cyc;
      end else if (exp_q.size() == 0) begin
        chk(0, "R9 unexpected command", int'(cmd_op), 0);
      end else begin
        exp_t e;
        string tag;
        e = exp_q.pop_front();
        if (idx == 0) tag = "R2 precharge";
        else if (idx == 1) tag = "R2 R5 first mode set";
        else if (idx < 10) tag = "R3 init refresh";
        else if (idx == 10) tag = "R4 R5 second mode set";
        else tag = "R9 dummy access";
        chk(int'(cmd_op) == e.op, {tag, " op"}, int'(cmd_op), e.op);
        chk(int'(cmd_addr) == e.addr, {tag, " addr"}, int'(cmd_addr), e.addr);
        if (int'(cmd_op) == int'(OP_REFRESH)) pre_refs++;
        if (int'(cmd_op) == int'(OP_MODE)) begin
          mrs_seen++;
          if (mrs_seen == 2) chk(pre_refs == 8, "R7 refreshes before timer", pre_refs, 8);
        end
        if (idx == 1 || idx == 5 || idx == 9 || idx == 10) begin
          gap_pending = 1;
          gap_from = cyc;
        end
        if (idx == LAST_IDX) begin
          chk(done == 1'b0, "R10 done low at last write", done, 0);
          chk_done_next = 1;
          last_wr_seen = 1;
        end
        idx++;
      end
    end
    prev_stall = cmd_valid && !cmd_ready;
    prev_op = int'(cmd_op);
    prev_addr = int'(cmd_addr);
  end

  task automatic wait_groups(input int n);
    int target;
    target = grp_count + n;
    while (grp_count < target) @(negedge clk);
  endtask

  initial begin
    push_exp(int'(OP_PRECHARGE), 0);
    push_exp(int'(OP_MODE), 'h88);
    for (int i = 0; i < 8; i++) push_exp(int'(OP_REFRESH), 0);
    push_exp(int'(OP_MODE), 'h88);
    for (int i = 0; i < DUMS; i++) begin
      push_exp(int'(OP_DRD), 4 * i);
      push_exp(int'(OP_DWR), 4 * i);
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 reset valid", cmd_valid, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R13 column select follows input
    @(posedge clk); #1 col9 = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(mux9 == 1'b1, "R13 mux select high", mux9, 1);
    @(posedge clk); #1 col9 = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(mux9 == 1'b0, "R13 mux select low", mux9, 0);

    while (!done) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all dummy pairs seen", exp_q.size(), 0);
    chk(refs_in_dummy >= 1, "R11 refresh ahead of dummy", refs_in_dummy, 1);

    rdy_mode = 0;
    wait_groups(3);
    chk(last_intv == INTV, "R7 fast interval", last_intv, INTV);
    wait_groups(1);
    chk(last_intv == INTV, "R7 fast interval again", last_intv, INTV);

    @(posedge clk); #1 small_mem = 1'b1;
    wait_groups(3);
    chk(last_intv == 2 * INTV, "R8 slow interval", last_intv, 2 * INTV);
    @(posedge clk); #1 small_mem = 1'b0;
    wait_groups(3);
    chk(last_intv == INTV, "R7 fast interval restored", last_intv, INTV);

    max_run = 0;
    rdy_mode = 2;
    repeat (3 * INTV) @(posedge clk);
    rdy_mode = 0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(max_run >= 3 * BURST, "R11 queued refreshes drained", max_run, 3 * BURST);
    chk(done == 1'b1, "R10 done stays high", done, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule